// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

This block is an 8-bit timer/counter with two equality-compare channels, driven from a small CPU register bus. A 3-bit clock selector either halts the counter or chooses a tick rate from a free-running prescaler. A mode bit selects between wrap-around counting and clear-when-reaching-compare-A counting. Three event flags are kept: overflow, compare A and compare B. Each flag drives an interrupt request line through its enable bit. A flag clears either on a per-source acknowledge pulse or when software writes a one to its bit.

Software can always read and write the counter, and a write overrides any count or clear in the same cycle. A counter write also suppresses compare matches at the next timer tick. This stops a freshly loaded count that equals a compare register from raising a spurious flag, and it holds even while the timer is halted. The bus has no back-pressure. A write takes effect at the clock edge on which `bus_we` is high, and `bus_rdata` follows `bus_addr` combinationally.

Register map (address: content):
- 0, control: bits [2:0] are the clock select and bit 3 is the clear-on-compare mode.
- 1: counter.
- 2: compare A.
- 3: compare B.
- 4: interrupt enables.
- 5: flags, which are write-one-to-clear.

In registers 4 and 5, bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. `irq` and `irq_ack` use the same bit order.

Top module: `dual_cmp_timer`

## Requirements
- R1: Clock select 0, 6 or 7 (control bits [2:0]) halts the counter, and the counter stays readable and writable at address 1 while halted.
- R2: A bus write to address 1 loads the counter at that edge, overriding any increment or clear due in the same cycle.
- R3: Clock select codes 1, 2, 3, 4, 5 advance the counter once every 1, 8, 64, 256, 1024 clocks respectively.
- R4: With control bit 3 low, the counter wraps from 0xFF to 0x00 on a tick, and that tick sets flag bit 0.
- R5: With control bit 3 high, the tick taken while the counter equals compare A loads zero instead of incrementing and sets flag bit 0.
- R6: When the counter equals compare A (or B) during a tick interval, flag bit 1 (or bit 2) is set by the tick that ends that interval, one tick after the equality first appears.
- R7: A counter write suppresses both compare flags at the next tick, whether that tick comes at once or after a halt.
- R8: `irq[i]` is high exactly when flag bit i and enable bit i (address 4) are both set.
- R9: A flag clears on a pulse of `irq_ack[i]` or on a write to address 5 with bit i set, and writing zero bits leaves the other flags alone.
- R10: When a set event and a clear (acknowledge or write-one) hit the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ack | input | 3 | Per-source interrupt acknowledge pulse |
| irq | output | 3 | Per-source interrupt request |

## Verification
Two pairs of events can share a cycle here.

The first pair is a compare match and a counter write, or the match-blocking window that such a write opens. The bench provokes this by loading a value equal to a compare register, both while halted and while running. The flag must stay clear through the next tick and still set on a later natural match.

The second pair is a flag being set by a match while it is being cleared by acknowledge and write-one. The bench issues both clears exactly on the tick edge that ends the equality interval and judges the outcome from the flag register: the flag must read back as set.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 3;
  localparam int N_SRC  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;

  localparam int SRC_OVF = 0;
  localparam int SRC_CMA = 1;
  localparam int SRC_CMB = 2;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             halted;
  int               sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // Map each select code to a tick period of 2**sh clocks.
  always_comb begin
    halted = 1'b0;
    sh     = 0;
    case (sel)
      3'd1:    sh = 0;
      3'd2:    sh = 3;
      3'd3:    sh = 6;
      3'd4:    sh = 8;
      3'd5:    sh = 10;
      default: halted = 1'b1;
    endcase
    mask = (PRE_W'(1) << sh) - PRE_W'(1);
    tick = !halted && ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctc,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt,
  output logic             set_ovf,
  output logic             set_a,
  output logic             set_b
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic blk_q;
  logic eq_a, eq_b, advance;

  assign eq_a    = (cnt == cmp_a);
  assign eq_b    = (cnt == cmp_b);
  assign advance = tick && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      blk_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt   <= wr_data;
      blk_q <= 1'b1;
    end else if (tick) begin
      blk_q <= 1'b0;
      cnt   <= (ctc && eq_a) ? '0 : cnt + 1'b1;
    end
  end

  assign set_a   = advance && !blk_q && eq_a;
  assign set_b   = advance && !blk_q && eq_b;
  assign set_ovf = advance && (ctc ? eq_a : (cnt == CNT_MAX));

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  a_r2_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wr_data)));
  a_r5_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ctc && eq_a) |=> (cnt == '0));
  a_r7_block_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !(set_a || set_b));
endmodule

// File: rtl/timer_flag.sv
module timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [2:0]       irq_ack,
  output logic [2:0]       irq
);
  localparam int CTRL_W = 4;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmpa_q, cmpb_q, cnt;
  logic [N_SRC-1:0]  ien_q, flags, set_v, w1c_v;
  logic              tick, cnt_wr, ctc;

  assign ctc    = ctrl_q[3];
  assign cnt_wr = bus_we && (bus_addr == A_COUNT);
  assign w1c_v  = (bus_we && (bus_addr == A_FLAG)) ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      ien_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL:  ctrl_q <= bus_wdata[CTRL_W-1:0];
        A_CMPA:  cmpa_q <= bus_wdata;
        A_CMPB:  cmpb_q <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_COUNT: bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmpa_q;
      A_CMPB:  bus_rdata = cmpb_q;
      A_IEN:   bus_rdata = {{(CNT_W-N_SRC){1'b0}}, ien_q};
      A_FLAG:  bus_rdata = {{(CNT_W-N_SRC){1'b0}}, flags};
      default: bus_rdata = '0;
    endcase
  end

  timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q[2:0]), .tick(tick)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctc(ctc), .cnt_wr(cnt_wr),
    .wr_data(bus_wdata), .cmp_a(cmpa_q), .cmp_b(cmpb_q), .cnt(cnt),
    .set_ovf(set_v[SRC_OVF]), .set_a(set_v[SRC_CMA]), .set_b(set_v[SRC_CMB])
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    timer_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_v[g]),
      .clr(w1c_v[g] | irq_ack[g]), .flag(flags[g])
    );
  end

  assign irq = flags & ien_q;

  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !ctc && (cnt == '1)) |=> (flags[SRC_OVF] && (cnt == '0)));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ien_q[SRC_CMA]) |-> !irq[SRC_CMA]);
endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  dual_cmp_timer i_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Halt, load compares with v, counter with v-2, clear flags, run at code 1.
  task automatic arm(input logic [7:0] v, input logic [7:0] ctl);
    wr(3'd0, 8'h00);
    wr(3'd2, v);
    wr(3'd3, v);
    wr(3'd1, v - 8'd2);
    wr(3'd5, 8'h07);
    wr(3'd0, ctl);
  endtask

  task automatic period(input logic [2:0] code, input int exp);
    logic [7:0] a, b;
    int n;
    wr(3'd0, {5'd0, code});
    rd(3'd1, a);
    n = 0;
    do begin step(1); rd(3'd1, b); n++; end while (b == a && n < 3000);
    a = b;
    n = 0;
    do begin step(1); rd(3'd1, b); n++; end while (b == a && n < 3000);
    chk($sformatf("R3 period code %0d", code), n, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    step(2);
    rst_n = 1'b1;
    step(1);

    // Reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("reset reg %0d", a), d, 0);
    end
    chk("reset irq", irq, 0);

    // R1: halted counter is readable/writable and does not move
    wr(3'd1, 8'h05);
    step(10);
    rd(3'd1, d); chk("R1 halted code 0", d, 8'h05);
    for (int c = 6; c < 8; c++) begin
      wr(3'd0, 8'(c));
      step(1100);
      rd(3'd1, d); chk($sformatf("R1 halted code %0d", c), d, 8'h05);
    end

    // R2: write overrides the tick on the same edge
    wr(3'd0, 8'h01);
    step(5);
    wr(3'd1, 8'h40);
    rd(3'd1, d); chk("R2 write wins", d, 8'h40);
    step(1);
    rd(3'd1, d); chk("R2 resumes", d, 8'h41);

    // R3: prescaled periods
    period(3'd1, 1);
    period(3'd2, 8);
    period(3'd3, 64);
    period(3'd4, 256);
    period(3'd5, 1024);

    // R6: full sweep of compare values, both channels, normal mode
    for (int v = 0; v < 256; v++) begin
      arm(8'(v), 8'h01);
      step(2);
      rd(3'd5, d); chk($sformatf("R6 before match v=%0d", v), d & 8'h06, 0);
      step(1);
      rd(3'd5, d); chk($sformatf("R6 after match v=%0d", v), d & 8'h06, 8'h06);
    end

    // R4: wrap sets overflow
    arm(8'hFF, 8'h01);
    step(2);
    rd(3'd5, d); chk("R4 no ovf before wrap", d & 1, 0);
    step(1);
    rd(3'd5, d); chk("R4 ovf on wrap", d & 1, 1);
    rd(3'd1, d); chk("R4 count wrapped", d, 8'h00);

    // R5: clear-on-compare-A for several compare values
    for (int n = 2; n < 12; n++) begin
      wr(3'd0, 8'h00);
      wr(3'd2, 8'(n));
      wr(3'd3, 8'hF0);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h07);
      wr(3'd0, 8'h09);
      step(n);
      rd(3'd1, d); chk($sformatf("R5 reaches top n=%0d", n), d, n);
      rd(3'd5, d); chk($sformatf("R5 no ovf yet n=%0d", n), d & 1, 0);
      step(1);
      rd(3'd1, d); chk($sformatf("R5 cleared n=%0d", n), d, 0);
      rd(3'd5, d); chk($sformatf("R5 ovf and A n=%0d", n), d & 3, 3);
    end

    // R7: write equal to compare while halted blocks the next tick
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h10);
    wr(3'd2, 8'h10);
    wr(3'd1, 8'h10);
    wr(3'd5, 8'h07);
    step(20);
    wr(3'd0, 8'h01);
    step(1);
    rd(3'd1, d); chk("R7 halted block count", d, 8'h11);
    rd(3'd5, d); chk("R7 halted block flags", d & 6, 0);
    // R7: write equal to compare while running
    wr(3'd3, 8'h30);
    wr(3'd2, 8'h30);
    wr(3'd1, 8'h30);
    wr(3'd5, 8'h07);
    step(2);
    rd(3'd5, d); chk("R7 running block flags", d & 6, 0);

    // R10: set and clear on the same edge
    arm(8'h20, 8'h01);
    step(2);
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h06; irq_ack = 3'b110;
    @(negedge clk);
    bus_we = 1'b0; irq_ack = 3'b000;
    wr(3'd0, 8'h00);
    rd(3'd5, d); chk("R10 set wins", d, 8'h06);

    // R8: irq gating
    chk("R8 irq disabled", irq, 0);
    wr(3'd4, 8'h07);
    chk("R8 irq enabled", irq, 3'b110);
    wr(3'd4, 8'h04);
    chk("R8 irq partial enable", irq, 3'b100);
    wr(3'd4, 8'h07);

    // R9: ack and write-one-to-clear
    @(negedge clk); irq_ack = 3'b010;
    @(negedge clk); irq_ack = 3'b000;
    rd(3'd5, d); chk("R9 ack clears A only", d, 8'h04);
    chk("R9 irq after ack", irq, 3'b100);
    wr(3'd5, 8'h00);
    rd(3'd5, d); chk("R9 zero write keeps flags", d, 8'h04);
    wr(3'd5, 8'h04);
    rd(3'd5, d); chk("R9 w1c clears B", d, 8'h00);
    chk("R9 irq after w1c", irq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule